// File: doc/BRIEF.md
# Fractional-N feedback divider controller

This block is the feedback divider of a fractional-N PLL. It divides the clock it runs on (the VCO-side clock) by an average ratio of N + F/M. It emits one single-cycle pulse at the end of every divided period. Each period lasts either N or N+1 input cycles. A first-order accumulator chooses between the two: it adds F once per output period and wraps at M. Each wrap stretches that period by one cycle.

Software-side logic drives a set of configuration fields:
- an integer value N, a fraction F and a modulus M;
- an integer-mode request, and an enable that switches to integer behaviour when F is zero;
- an output-divider exponent, and a select that keeps the output divider out of the loop.

Each configuration is range-checked. A bad one raises an error flag and is dropped. A good one is stored, but it reaches the divider only at the next period boundary, so no period is ever cut short.

A hold input keeps the period counter and the accumulator cleared. The block also reports two values for the loop: the factor by which the output divider scales the loop ratio, and the integer ratio seen by the loop after that scaling.

Top module: `fracn_fb_divider`

## Requirements
- R1: During and after synchronous reset, and before any valid configuration is loaded: `div_pulse` and `cfg_err` are 0, `int_active` is 1, `fb_scale` is 1 and `eff_int` is 16. This is an integer-mode default with N = 16.
- R2: In integer mode (`cfg_int` = 1) every output period is exactly N cycles. F and M are ignored, even when F is not below M, and such a configuration raises no error. `div_pulse` is never high on two cycles in a row.
- R3: In fractional mode, period k lasts N+1 cycles when `acc_{k-1}` + F is at least M, and N cycles otherwise. Here `acc_0` = 0 at the start of a run, and `acc_k` is (`acc_{k-1}` + F) mod M. Over any M consecutive periods exactly F of them are long. `int_active` reads 0.
- R4: When `cfg_int` = 0 and F = 0, the divider behaves as integer mode and `int_active` = 1 only if `cfg_auto_int` = 1. Otherwise it stays in fractional mode (`int_active` = 0) with N-cycle periods. With the switch active, N = 16 is accepted.
- R5: `cfg_err` goes high in the cycle after an invalid configuration is presented, and low in the cycle after a valid one is presented. A configuration is invalid when any of the following holds:
  - effective integer mode and N < 16;
  - fractional mode and N outside 19..4091;
  - fractional mode and M < 2;
  - fractional mode and F >= M.
- R6: An invalid configuration is never loaded. Periods, `fb_scale` and `eff_int` keep the values of the last valid configuration.
- R7: A configuration that becomes valid in the middle of a period does not change that period. It governs the periods that start from the next boundary on.
- R8: While `hold` is 1, `div_pulse` stays 0. The counter and accumulator are cleared, and valid configurations are still stored. In the cycle after `hold` is first sampled low, `div_pulse` is 1 and the first full period starts.
- R9: `fb_scale` is 1 when `cfg_fb_bypass` = 1. Otherwise it is 2^`cfg_odiv` capped at 16, which gives 1, 2, 4, 8, 16, 16, 16, 16 for `cfg_odiv` values 0 through 7. `eff_int` is N × `fb_scale`. Both outputs follow the loaded configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-side clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | Holds the counter and accumulator cleared and suppresses the output pulse |
| cfg_n | input | 16 | Integer division value N |
| cfg_f | input | 12 | Fraction F |
| cfg_m | input | 12 | Modulus M |
| cfg_int | input | 1 | Integer-mode request |
| cfg_auto_int | input | 1 | Switch to integer behaviour when F is zero |
| cfg_odiv | input | 3 | Output divider exponent (divide by 2^value) |
| cfg_fb_bypass | input | 1 | 1 keeps the output divider out of the loop ratio |
| div_pulse | output | 1 | One-cycle pulse at each period boundary |
| cfg_err | output | 1 | Presented configuration was out of range (one cycle later) |
| int_active | output | 1 | Loaded configuration runs as integer-N |
| fb_scale | output | 5 | Loop-ratio factor from the output divider |
| eff_int | output | 20 | N multiplied by fb_scale |

## Verification
The assertions check several properties on every cycle:
- the counter steps down by one between boundaries, so no mid-period reload happens;
- an invalid configuration leaves the stored one unchanged;
- the accumulator stays below the loaded modulus;
- the pulse stays low under hold and is never high on two cycles in a row;
- the scale factor is a single power of two no larger than 16.

Only the bench scenarios show the exact period lengths. These cover the N/N+1 pattern and long-period count of the fractional sequence, the integer switch when F is zero with and without the enable, the deferral of a mid-period change to the next boundary, and the full scale table for every output-divider value.

// File: rtl/fnd_pkg.sv
// Package fnd_pkg
// Shared widths and the configuration record used by the fractional-N
// feedback divider. Assumes the field widths below match the programming
// side that drives the configuration inputs.
package fnd_pkg;

    localparam int N_W      = 16;            // integer divide value width
    localparam int FM_W     = 12;            // fraction / modulus width
    localparam int OD_W     = 3;             // output divider exponent width
    localparam int CAP_LOG2 = 4;             // cap of output divider in loop (2^4 = 16)
    localparam int SCALE_W  = CAP_LOG2 + 1;  // width of the scale factor
    localparam int EFF_W    = N_W + CAP_LOG2;// width of N times the scale

    // One stored configuration, already reduced to its effective mode.
    typedef struct packed {
        logic [N_W-1:0]  n;
        logic [FM_W-1:0] f;
        logic [FM_W-1:0] m;
        logic            int_eff;
        logic [OD_W-1:0] odiv;
        logic            fb_bypass;
    } fnd_cfg_t;

endpackage

// File: rtl/fnd_cfg_check.sv
// Module fnd_cfg_check
// Purely combinational range check of a presented configuration. It also
// resolves the effective mode: integer when requested, or when the fraction
// is zero and the automatic switch is enabled. F and M are not examined in
// effective integer mode. Assumes inputs are stable within a cycle.
module fnd_cfg_check #(
    parameter int N_W        = 16,
    parameter int FM_W       = 12,
    parameter int INT_N_MIN  = 16,
    parameter int FRAC_N_MIN = 19,
    parameter int FRAC_N_MAX = 4091,
    parameter int M_MIN      = 2
) (
    input  logic [N_W-1:0]  n,
    input  logic [FM_W-1:0] f,
    input  logic [FM_W-1:0] m,
    input  logic            int_req,
    input  logic            auto_int,
    output logic            int_eff,
    output logic            valid
);

    logic f_zero;
    logic n_ok;
    logic fm_ok;

    // Resolve mode, then test each field against the bounds of that mode.
    always_comb begin
        f_zero  = (f == '0);
        int_eff = int_req | (auto_int & f_zero);
        if (int_eff) begin
            n_ok  = (n >= N_W'(INT_N_MIN));
            fm_ok = 1'b1;
        end else begin
            n_ok  = (n >= N_W'(FRAC_N_MIN)) && (n <= N_W'(FRAC_N_MAX));
            fm_ok = (m >= FM_W'(M_MIN)) && (f < m);
        end
        valid = n_ok & fm_ok;
    end

endmodule

// File: rtl/fnd_frac_accum.sv
// Module fnd_frac_accum
// First-order fraction accumulator. It offers a carry for the period about
// to start and advances once per period (step). A stale accumulator value at
// or above a newly loaded modulus is treated as zero, so one subtraction
// always suffices. Assumes f < m whenever int_eff is low (checked upstream).
module fnd_frac_accum #(
    parameter int FM_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            step,
    input  logic            int_eff,
    input  logic [FM_W-1:0] f,
    input  logic [FM_W-1:0] m,
    output logic            carry,
    output logic [FM_W-1:0] acc_q
);

    logic [FM_W-1:0] acc_base;
    logic [FM_W:0]   sum;
    logic [FM_W:0]   diff;
    logic [FM_W-1:0] acc_next;

    // Next accumulator value and the wrap that lengthens this period.
    always_comb begin
        acc_base = (acc_q >= m) ? '0 : acc_q;
        sum      = {1'b0, acc_base} + {1'b0, f};
        diff     = sum - {1'b0, m};
        carry    = !int_eff && (sum >= {1'b0, m});
        acc_next = carry ? diff[FM_W-1:0] : sum[FM_W-1:0];
    end

    // Accumulator register: cleared on reset, hold or integer periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (hold) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= int_eff ? '0 : acc_next;
        end
    end

    // R3: after a fractional step the residue is below the modulus used.
    p_step_residue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hold && !int_eff) |=> (acc_q < $past(m)));

endmodule

// File: rtl/fnd_period_counter.sv
// Module fnd_period_counter
// Down-counter that times one output period. A count of zero marks the
// boundary: the next length (n plus an optional extra cycle) is loaded and
// a one-cycle pulse follows. Hold keeps the count at zero and the pulse
// low, so the first edge after hold releases is a boundary.
module fnd_period_counter #(
    parameter int N_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic [N_W-1:0] n_len,
    input  logic           add_one,
    output logic           boundary,
    output logic           div_pulse
);

    localparam int CW = N_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] len;

    // Boundary detect and length of the period about to start.
    always_comb begin
        boundary = (cnt == '0);
        len      = {1'b0, n_len} + {{N_W{1'b0}}, add_one};
    end

    // Count register and registered boundary pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            div_pulse <= 1'b0;
        end else if (hold) begin
            cnt       <= '0;
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= boundary;
            if (boundary) begin
                cnt <= len - CW'(1);
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    // R7: between boundaries the count only steps down, never reloads.
    p_no_midload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/fnd_fb_scale.sv
// Module fnd_fb_scale
// Works out how the output divider scales the loop ratio: bypassed gives 1,
// otherwise 2^odiv limited to 2^CAP_LOG2. Also forms N times that factor.
// A generate branch drops the clamp when the cap cannot be exceeded.
module fnd_fb_scale #(
    parameter int N_W      = 16,
    parameter int OD_W     = 3,
    parameter int CAP_LOG2 = 4
) (
    input  logic [N_W-1:0]        n,
    input  logic [OD_W-1:0]       odiv,
    input  logic                  fb_bypass,
    output logic [CAP_LOG2:0]     scale,
    output logic [N_W+CAP_LOG2-1:0] eff_int
);

    localparam int OD_MAX = (1 << OD_W) - 1;

    logic [OD_W-1:0] sh_raw;
    logic [OD_W-1:0] sh;

    // Shift before capping: zero when the output divider is out of the loop.
    always_comb begin
        sh_raw = fb_bypass ? '0 : odiv;
    end

    generate
        if (CAP_LOG2 >= OD_MAX) begin : g_no_cap
            // Cap unreachable: use the exponent as is.
            always_comb begin
                sh = sh_raw;
            end
        end else begin : g_cap
            // Limit the exponent to the cap.
            always_comb begin
                sh = (sh_raw > OD_W'(CAP_LOG2)) ? OD_W'(CAP_LOG2) : sh_raw;
            end
        end
    endgenerate

    // Scale factor and scaled integer ratio.
    always_comb begin
        scale   = (CAP_LOG2+1)'(1) << sh;
        eff_int = (N_W+CAP_LOG2)'(n) << sh;
    end

endmodule

// File: rtl/fracn_fb_divider.sv
// Module fracn_fb_divider
// Top of the fractional-N feedback divider. Presented configurations are
// range checked every cycle; valid ones go into a staging register, which is
// copied to the loaded register at each period boundary. The period counter
// and accumulator read the staging register at that same boundary, so a
// change never alters a period in progress. Assumes a single clock domain.
module fracn_fb_divider
    import fnd_pkg::*;
#(
    parameter int INT_N_MIN  = 16,
    parameter int FRAC_N_MIN = 19,
    parameter int FRAC_N_MAX = 4091,
    parameter int M_MIN      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [N_W-1:0]     cfg_n,
    input  logic [FM_W-1:0]    cfg_f,
    input  logic [FM_W-1:0]    cfg_m,
    input  logic               cfg_int,
    input  logic               cfg_auto_int,
    input  logic [OD_W-1:0]    cfg_odiv,
    input  logic               cfg_fb_bypass,
    output logic               div_pulse,
    output logic               cfg_err,
    output logic               int_active,
    output logic [SCALE_W-1:0] fb_scale,
    output logic [EFF_W-1:0]   eff_int
);

    localparam fnd_cfg_t DEF_CFG = '{
        n:         N_W'(INT_N_MIN),
        f:         '0,
        m:         FM_W'(M_MIN),
        int_eff:   1'b1,
        odiv:      '0,
        fb_bypass: 1'b0
    };

    logic            in_int_eff;
    logic            in_valid;
    fnd_cfg_t        staged;
    fnd_cfg_t        loaded;
    logic            boundary;
    logic            step;
    logic            carry;
    logic [FM_W-1:0] acc_q;

    fnd_cfg_check #(
        .N_W        (N_W),
        .FM_W       (FM_W),
        .INT_N_MIN  (INT_N_MIN),
        .FRAC_N_MIN (FRAC_N_MIN),
        .FRAC_N_MAX (FRAC_N_MAX),
        .M_MIN      (M_MIN)
    ) u_check (
        .n        (cfg_n),
        .f        (cfg_f),
        .m        (cfg_m),
        .int_req  (cfg_int),
        .auto_int (cfg_auto_int),
        .int_eff  (in_int_eff),
        .valid    (in_valid)
    );

    // Staging register: keeps the most recent valid configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= DEF_CFG;
        end else if (in_valid) begin
            staged <= '{
                n:         cfg_n,
                f:         cfg_f,
                m:         cfg_m,
                int_eff:   in_int_eff,
                odiv:      cfg_odiv,
                fb_bypass: cfg_fb_bypass
            };
        end
    end

    // Error flag: reflects the check of the previous cycle's inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= !in_valid;
        end
    end

    // A period starts at a boundary only when not held.
    always_comb begin
        step = boundary & ~hold;
    end

    fnd_frac_accum #(
        .FM_W (FM_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .step    (step),
        .int_eff (staged.int_eff),
        .f       (staged.f),
        .m       (staged.m),
        .carry   (carry),
        .acc_q   (acc_q)
    );

    fnd_period_counter #(
        .N_W (N_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .n_len     (staged.n),
        .add_one   (carry),
        .boundary  (boundary),
        .div_pulse (div_pulse)
    );

    // Loaded register: the configuration governing the current period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded <= DEF_CFG;
        end else if (step) begin
            loaded <= staged;
        end
    end

    fnd_fb_scale #(
        .N_W      (N_W),
        .OD_W     (OD_W),
        .CAP_LOG2 (CAP_LOG2)
    ) u_scale (
        .n         (loaded.n),
        .odiv      (loaded.odiv),
        .fb_bypass (loaded.fb_bypass),
        .scale     (fb_scale),
        .eff_int   (eff_int)
    );

    // Mode of the loaded configuration, for the outside.
    always_comb begin
        int_active = loaded.int_eff;
    end

    // R6: a rejected configuration leaves the staged one untouched.
    p_reject_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> $stable(staged));

    // R8: no pulse follows a cycle in which hold was sampled high.
    p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !div_pulse);

    // R2: every period is at least two cycles, so pulses never touch.
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R3: in a fractional period the residue is below the loaded modulus.
    p_acc_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!loaded.int_eff) |-> (acc_q < loaded.m));

    // R9: the scale is one power of two no larger than the cap.
    p_scale_pow2_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(fb_scale) == 1) && (fb_scale <= SCALE_W'(1 << CAP_LOG2)));

endmodule

// File: tb/fracn_fb_divider_bench.sv
// Directed bench for fracn_fb_divider: one task per scenario.
module fracn_fb_divider_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b1;
    logic [15:0] cfg_n = 16'd16;
    logic [11:0] cfg_f = 12'd0;
    logic [11:0] cfg_m = 12'd2;
    logic        cfg_int = 1'b1;
    logic        cfg_auto_int = 1'b0;
    logic [2:0]  cfg_odiv = 3'd0;
    logic        cfg_fb_bypass = 1'b0;
    logic        div_pulse;
    logic        cfg_err;
    logic        int_active;
    logic [4:0]  fb_scale;
    logic [19:0] eff_int;

    int checks = 0;
    int errors = 0;

    fracn_fb_divider u_fracn_fb_divider (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold          (hold),
        .cfg_n         (cfg_n),
        .cfg_f         (cfg_f),
        .cfg_m         (cfg_m),
        .cfg_int       (cfg_int),
        .cfg_auto_int  (cfg_auto_int),
        .cfg_odiv      (cfg_odiv),
        .cfg_fb_bypass (cfg_fb_bypass),
        .div_pulse     (div_pulse),
        .cfg_err       (cfg_err),
        .int_active    (int_active),
        .fb_scale      (fb_scale),
        .eff_int       (eff_int)
    );

    always #10 clk = ~clk;

    task automatic check_eq(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(int n, int f, int m, bit i, bit a, int od, bit bp);
        @(negedge clk);
        cfg_n = 16'(n); cfg_f = 12'(f); cfg_m = 12'(m);
        cfg_int = i; cfg_auto_int = a; cfg_odiv = 3'(od); cfg_fb_bypass = bp;
    endtask

    // Hold a few cycles, release, and see the first boundary pulse.
    task automatic start_run();
        @(negedge clk);
        hold = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_eq("R8 pulse low under hold", div_pulse, 0);
        end
        hold = 1'b0;
        @(negedge clk);
        check_eq("R8 pulse right after hold release", div_pulse, 1);
    endtask

    // Cycles from the current pulse sample to the next pulse sample.
    task automatic measure(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!div_pulse && len < 70000);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_eq("R1 pulse in reset", div_pulse, 0);
        check_eq("R1 err in reset", cfg_err, 0);
        check_eq("R1 int_active in reset", int_active, 1);
        check_eq("R1 fb_scale in reset", fb_scale, 1);
        check_eq("R1 eff_int in reset", eff_int, 16);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R1 pulse after reset under hold", div_pulse, 0);
        check_eq("R1 int_active after reset", int_active, 1);
    endtask

    task automatic t_errors();
        set_cfg(15, 0, 2, 1, 0, 0, 0); @(negedge clk);
        check_eq("R5 int N=15 flagged", cfg_err, 1);
        set_cfg(16, 0, 2, 1, 0, 0, 0); @(negedge clk);
        check_eq("R5 int N=16 accepted", cfg_err, 0);
        set_cfg(18, 1, 4, 0, 0, 0, 0); @(negedge clk);
        check_eq("R5 frac N=18 flagged", cfg_err, 1);
        set_cfg(19, 1, 4, 0, 0, 0, 0); @(negedge clk);
        check_eq("R5 frac N=19 accepted", cfg_err, 0);
        set_cfg(4092, 1, 4, 0, 0, 0, 0); @(negedge clk);
        check_eq("R5 frac N=4092 flagged", cfg_err, 1);
        set_cfg(4091, 1, 4, 0, 0, 0, 0); @(negedge clk);
        check_eq("R5 frac N=4091 accepted", cfg_err, 0);
        set_cfg(20, 0, 1, 0, 0, 0, 0); @(negedge clk);
        check_eq("R5 frac M=1 flagged", cfg_err, 1);
        set_cfg(20, 4, 4, 0, 0, 0, 0); @(negedge clk);
        check_eq("R5 frac F=M flagged", cfg_err, 1);
        set_cfg(20, 3, 4, 0, 0, 0, 0); @(negedge clk);
        check_eq("R5 frac F=M-1 accepted", cfg_err, 0);
    endtask

    task automatic t_int_mode();
        int len;
        set_cfg(17, 9, 8, 1, 0, 0, 1); @(negedge clk);
        check_eq("R2 int ignores F>=M, no error", cfg_err, 0);
        start_run();
        check_eq("R2 int_active", int_active, 1);
        for (int k = 0; k < 4; k++) begin
            measure(len);
            check_eq("R2 int period", len, 17);
        end
    endtask

    task automatic t_frac_mode();
        int len;
        int acc;
        int exp_len;
        int longs;
        acc = 0; longs = 0;
        set_cfg(20, 3, 8, 0, 0, 0, 1);
        start_run();
        check_eq("R3 int_active low", int_active, 0);
        for (int k = 0; k < 16; k++) begin
            measure(len);
            if (acc + 3 >= 8) begin
                exp_len = 21; acc = acc + 3 - 8;
            end else begin
                exp_len = 20; acc = acc + 3;
            end
            if (len == 21) longs++;
            check_eq("R3 frac period", len, exp_len);
        end
        check_eq("R3 long periods in 2*M", longs, 6);
    endtask

    task automatic t_auto_int();
        int len;
        set_cfg(16, 0, 5, 0, 1, 0, 1); @(negedge clk);
        check_eq("R4 auto switch accepts N=16", cfg_err, 0);
        start_run();
        check_eq("R4 auto switch int_active", int_active, 1);
        for (int k = 0; k < 3; k++) begin
            measure(len);
            check_eq("R4 auto switch period", len, 16);
        end
        set_cfg(25, 0, 5, 0, 0, 0, 1);
        start_run();
        check_eq("R4 no auto switch stays fractional", int_active, 0);
        for (int k = 0; k < 3; k++) begin
            measure(len);
            check_eq("R4 frac F=0 period", len, 25);
        end
    endtask

    task automatic t_mid_change();
        int len;
        set_cfg(20, 0, 2, 1, 0, 0, 1);
        start_run();
        len = 0;
        do begin
            @(negedge clk);
            len++;
            if (len == 5) cfg_n = 16'd30;
        end while (!div_pulse && len < 70000);
        check_eq("R7 period in progress unchanged", len, 20);
        measure(len);
        check_eq("R7 new period length", len, 30);
    endtask

    task automatic t_reject();
        int len;
        set_cfg(30, 0, 2, 1, 0, 3, 0);
        measure(len);
        measure(len);
        check_eq("R9 scale odiv=3", fb_scale, 8);
        check_eq("R9 eff_int odiv=3", eff_int, 240);
        set_cfg(8, 0, 2, 1, 0, 0, 1);
        @(negedge clk);
        check_eq("R5 int N=8 flagged", cfg_err, 1);
        measure(len);
        measure(len);
        check_eq("R6 period kept", len, 30);
        check_eq("R6 fb_scale kept", fb_scale, 8);
        check_eq("R6 eff_int kept", eff_int, 240);
    endtask

    task automatic t_scale();
        int len;
        int exp_s;
        for (int bp = 0; bp < 2; bp++) begin
            for (int d = 0; d < 8; d++) begin
                set_cfg(16, 0, 2, 1, 0, d, bp[0]);
                measure(len);
                measure(len);
                exp_s = (bp == 1) ? 1 : ((d > 4) ? 16 : (1 << d));
                check_eq("R9 fb_scale", fb_scale, exp_s);
                check_eq("R9 eff_int", eff_int, 16 * exp_s);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_errors();
        t_int_mode();
        t_frac_mode();
        t_auto_int();
        t_mid_change();
        t_reject();
        t_scale();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule